// File: doc/BRIEF.md
# Single-Port Memory with SECDED Protection and Idle-Cycle Scrubbing

The block wraps a behavioural single-port RAM with a single-error-correct, double-error-detect Hamming code. Every user write is encoded before it enters the array. Every user read is checked one cycle after it is issued. A read with one flipped bit returns corrected data and raises a correctable flag. A read with two flipped bits raises an uncorrectable flag. The stored word is wider than the data word, and its width is picked in fixed steps of 18, 36 or 54 bits. The Hamming code fills the low bits of the stored word. Any padding bits above the code are written as zero and ignored on reads.

A scrub sequencer walks the address space in the background. It uses the port only in cycles in which the user drives neither read enable nor write enable. For each address it reads the word and checks it. If the word holds a single error, it writes the corrected word back. A user access that arrives in the middle of this sequence takes the port. The sequence is then dropped and restarted at the same address. A word that the scrubber finds uncorrectable is left untouched, and a sticky status output is raised. That output stays high until reset.

The scrub sequencer has three states:
- ISSUE: waits for an idle cycle and reads the scrub address.
- CHECK: decodes the word that was read. It takes one of four transitions:
  - abandon: a user access arrived, so it returns to ISSUE.
  - fix: the word had a single error, so it moves to WRITE.
  - advance-clean: the word was clean, so it returns to ISSUE for the next address.
  - advance-bad: the word was uncorrectable, so it sets the sticky flag and moves on to the next address.
- WRITE: takes one of two transitions:
  - commit: the port is idle, so it writes the corrected word and advances.
  - abandon: a user access arrived, so it returns to ISSUE at the same address.

Top module: `ecc_scrub_mem`

## Requirements
- R1: A user read (rd_en high, wr_en low) returns the last data written to that address on rd_data, with rd_valid high in the following cycle; err_corr and err_uncorr stay low for an undisturbed word.
- R2: If exactly one bit of the stored code of a word is flipped, including a check bit or the overall parity bit, a read returns the original data, and err_corr is high and err_uncorr low in the rd_valid cycle.
- R3: If two bits of the stored code of a word are flipped, a read raises err_uncorr and keeps err_corr low.
- R4: The scrub sequencer reads or writes the array only in cycles where both rd_en and wr_en are low.
- R5: The scrub address starts at 0, steps up by one after each finished check, and wraps from the last address to 0; single-bit errors found by the scrubber are written back corrected, so a later read shows no error.
- R6: A word that the scrubber finds uncorrectable is not rewritten, and scrub_uncorr rises and stays high until reset, even after that word is overwritten by the user.
- R7: A user access during a scrub check or write-back cancels that step; the scrubber restarts at the same address, and a write-back happens only after three consecutive idle cycles.
- R8: The stored word width is 18 bits for DATA_W up to 12, 36 bits for DATA_W 13 to 29, and 54 bits for DATA_W 30 to 47; padding bits above the code are ignored on reads.
- R9: With wr_en and rd_en both high, the write is performed and no read takes place (rd_valid stays low in the next cycle).
- R10: During reset, rd_valid, err_corr, err_uncorr and scrub_uncorr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | User address |
| wr_en | input | 1 | User write enable |
| rd_en | input | 1 | User read enable |
| wr_data | input | DATA_W | User write data |
| rd_data | output | DATA_W | Corrected read data, valid with rd_valid |
| rd_valid | output | 1 | High one cycle after a user read |
| err_corr | output | 1 | Read held a corrected single-bit error |
| err_uncorr | output | 1 | Read held an uncorrectable error |
| scrub_uncorr | output | 1 | Sticky: the scrubber found an uncorrectable word |

## Verification
The bench builds the main instance with DATA_W=16 and ADDR_W=4. This gives a 21-bit Hamming code inside a 36-bit stored word, so faults can be injected into data bits, check bits, the overall parity bit and padding bits. With 16 addresses, a full scrub pass takes at most 48 idle cycles, so the bench can watch both the wrap and the write-back. A second instance with DATA_W=40 and ADDR_W=2 reaches the 54-bit step, and the bench corrects a flip in its highest code bit. A traffic pattern that leaves at most two idle cycles in a row keeps every write-back cancelled. This shows that the scrubber never takes the port from the user and that it later retries the same word.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    typedef enum logic [1:0] {
        SC_ISSUE = 2'd0,
        SC_CHECK = 2'd1,
        SC_WRITE = 2'd2
    } scrub_state_e;

    // Number of Hamming check bits (without the overall parity bit)
    function automatic int ham_check_bits(input int k);
        for (int r = 1; r < 16; r++) begin
            if ((1 << r) >= k + r + 1) return r;
        end
        return 16;
    endfunction

    // Stored word width, chosen in fixed steps from the data width
    function automatic int stored_width(input int k);
        if (k <= 12) return 18;
        else if (k <= 29) return 36;
        else return 54;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
    parameter int DATA_W  = 16,
    parameter int STORE_W = 36
) (
    input  logic [DATA_W-1:0]  data_i,
    output logic [STORE_W-1:0] word_o
);
    localparam int R = ecc_pkg::ham_check_bits(DATA_W);
    localparam int N = DATA_W + R;

    always_comb begin
        logic [N:0] c;
        int j;
        c = '0;
        j = 0;
        // data bits go to every position that is not a power of two
        for (int i = 1; i <= N; i++) begin
            if ((i & (i - 1)) != 0) begin
                c[i] = data_i[j];
                j++;
            end
        end
        // check bit b covers every position whose index has bit b set
        for (int b = 0; b < R; b++) begin
            logic p;
            p = 1'b0;
            for (int i = 1; i <= N; i++) begin
                if (((i >> b) & 1) == 1) p = p ^ c[i];
            end
            c[1 << b] = p;
        end
        c[0]   = ^c[N:1];
        word_o = STORE_W'(c);
    end
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder #(
    parameter int DATA_W  = 16,
    parameter int STORE_W = 36
) (
    input  logic [STORE_W-1:0] word_i,
    output logic [DATA_W-1:0]  data_o,
    output logic [STORE_W-1:0] fixed_o,
    output logic               single_o,
    output logic               double_o
);
    localparam int R = ecc_pkg::ham_check_bits(DATA_W);
    localparam int N = DATA_W + R;

    always_comb begin
        logic [R-1:0] syn;
        logic         ovp;
        logic [N:0]   c;
        int           j;
        c   = word_i[N:0];
        syn = '0;
        for (int i = 1; i <= N; i++) begin
            if (c[i]) syn = syn ^ R'(i);
        end
        ovp      = ^c;
        single_o = 1'b0;
        double_o = 1'b0;
        if (ovp) begin
            if (syn == '0) begin
                c[0] = ~c[0];
            end else if (int'(syn) <= N) begin
                c[syn] = ~c[syn];
            end else begin
                double_o = 1'b1;
            end
            single_o = ~double_o;
        end else if (syn != '0) begin
            double_o = 1'b1;
        end
        data_o = '0;
        j = 0;
        for (int i = 1; i <= N; i++) begin
            if ((i & (i - 1)) != 0) begin
                data_o[j] = c[i];
                j++;
            end
        end
        fixed_o = STORE_W'(c);
    end
endmodule

// File: rtl/ecc_ram_array.sv
module ecc_ram_array #(
    parameter int ADDR_W  = 4,
    parameter int STORE_W = 36
) (
    input  logic               clk,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic               re_i,
    input  logic [STORE_W-1:0] wdata_i,
    output logic [STORE_W-1:0] q_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [STORE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
        if (re_i) q_o <= mem[addr_i];
    end
endmodule

// File: rtl/ecc_scrubber.sv
module ecc_scrubber #(
    parameter int ADDR_W  = 4,
    parameter int STORE_W = 36
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      user_busy_i,
    input  logic                      dec_single_i,
    input  logic                      dec_double_i,
    input  logic [STORE_W-1:0]        dec_fixed_i,
    output logic                      req_re_o,
    output logic                      req_we_o,
    output logic [ADDR_W-1:0]         req_addr_o,
    output logic [STORE_W-1:0]        req_wdata_o,
    output logic                      adv_o,
    output logic                      uncorr_o,
    output ecc_pkg::scrub_state_e     state_o
);
    import ecc_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    scrub_state_e       state, state_nxt;
    logic [ADDR_W-1:0]  saddr;
    logic [STORE_W-1:0] fix_buf;
    logic               sticky;
    logic               take_fix;
    logic               flag_bad;

    // state register and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SC_ISSUE;
            saddr   <= '0;
            fix_buf <= '0;
            sticky  <= 1'b0;
        end else begin
            state <= state_nxt;
            if (adv_o) saddr <= (saddr == LAST) ? '0 : saddr + 1'b1;
            if (take_fix) fix_buf <= dec_fixed_i;
            if (flag_bad) sticky <= 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            SC_ISSUE: if (!user_busy_i) state_nxt = SC_CHECK;
            SC_CHECK: begin
                if (user_busy_i)       state_nxt = SC_ISSUE;  // abandon
                else if (dec_single_i) state_nxt = SC_WRITE;  // fix
                else                   state_nxt = SC_ISSUE;  // advance-clean / advance-bad
            end
            SC_WRITE: state_nxt = SC_ISSUE;                   // commit or abandon
            default:  state_nxt = SC_ISSUE;
        endcase
    end

    // outputs
    always_comb begin
        req_re_o = 1'b0;
        req_we_o = 1'b0;
        adv_o    = 1'b0;
        take_fix = 1'b0;
        flag_bad = 1'b0;
        unique case (state)
            SC_ISSUE: req_re_o = !user_busy_i;
            SC_CHECK: begin
                if (!user_busy_i) begin
                    take_fix = dec_single_i;
                    adv_o    = !dec_single_i;
                    flag_bad = dec_double_i;
                end
            end
            SC_WRITE: begin
                req_we_o = !user_busy_i;
                adv_o    = !user_busy_i;
            end
            default: ;
        endcase
    end

    assign req_addr_o  = saddr;
    assign req_wdata_o = fix_buf;
    assign uncorr_o    = sticky;
    assign state_o     = state;
endmodule

// File: rtl/ecc_scrub_mem.sv
module ecc_scrub_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err_corr,
    output logic              err_uncorr,
    output logic              scrub_uncorr
);
    localparam int STORE_W = ecc_pkg::stored_width(DATA_W);

    logic [STORE_W-1:0] enc_word, arr_q, arr_wdata, dec_fixed, scr_wdata;
    logic [ADDR_W-1:0]  arr_addr, scr_addr;
    logic               arr_we, arr_re, user_busy, user_rd, rd_pend;
    logic               scr_re, scr_we, scr_adv, dec_single, dec_double;
    ecc_pkg::scrub_state_e scr_state;

    assign user_busy = wr_en | rd_en;
    assign user_rd   = rd_en & ~wr_en;

    ecc_encoder #(.DATA_W(DATA_W), .STORE_W(STORE_W)) u_enc (
        .data_i (wr_data),
        .word_o (enc_word)
    );

    // user accesses own the port; the scrubber fills idle cycles
    assign arr_we    = wr_en | scr_we;
    assign arr_re    = user_rd | scr_re;
    assign arr_addr  = user_busy ? addr : scr_addr;
    assign arr_wdata = wr_en ? enc_word : scr_wdata;

    ecc_ram_array #(.ADDR_W(ADDR_W), .STORE_W(STORE_W)) u_array (
        .clk     (clk),
        .addr_i  (arr_addr),
        .we_i    (arr_we),
        .re_i    (arr_re),
        .wdata_i (arr_wdata),
        .q_o     (arr_q)
    );

    ecc_decoder #(.DATA_W(DATA_W), .STORE_W(STORE_W)) u_dec (
        .word_i   (arr_q),
        .data_o   (rd_data),
        .fixed_o  (dec_fixed),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    ecc_scrubber #(.ADDR_W(ADDR_W), .STORE_W(STORE_W)) u_scrub (
        .clk          (clk),
        .rst_n        (rst_n),
        .user_busy_i  (user_busy),
        .dec_single_i (dec_single),
        .dec_double_i (dec_double),
        .dec_fixed_i  (dec_fixed),
        .req_re_o     (scr_re),
        .req_we_o     (scr_we),
        .req_addr_o   (scr_addr),
        .req_wdata_o  (scr_wdata),
        .adv_o        (scr_adv),
        .uncorr_o     (scrub_uncorr),
        .state_o      (scr_state)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rd_pend <= 1'b0;
        else        rd_pend <= user_rd;
    end

    assign rd_valid   = rd_pend;
    assign err_corr   = rd_pend & dec_single;
    assign err_uncorr = rd_pend & dec_double;
endmodule

// File: rtl/ecc_scrub_chk.sv
module ecc_scrub_chk #(
    parameter int ADDR_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_en,
    input logic                  wr_en,
    input logic                  rd_valid,
    input logic                  err_corr,
    input logic                  err_uncorr,
    input logic                  scrub_uncorr,
    input logic                  scr_re,
    input logic                  scr_we,
    input logic                  scr_adv,
    input logic [ADDR_W-1:0]     scr_addr,
    input ecc_pkg::scrub_state_e scr_state
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rd_valid);

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en) |=> !rd_valid);

    p_flag_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr || err_uncorr) |-> (rd_valid && !(err_corr && err_uncorr)));

    p_scrub_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_re || scr_we) |-> (!rd_en && !wr_en));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_adv && scr_addr == LAST) |=> (scr_addr == '0));

    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_adv && scr_addr != LAST) |=> (scr_addr == ADDR_W'($past(scr_addr) + 1'b1)));

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scrub_uncorr |=> scrub_uncorr);

    p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_state == ecc_pkg::SC_CHECK && (rd_en || wr_en))
        |=> (scr_state == ecc_pkg::SC_ISSUE && $stable(scr_addr)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !scr_adv |=> $stable(scr_addr));
endmodule

bind ecc_scrub_mem ecc_scrub_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .rd_valid     (rd_valid),
    .err_corr     (err_corr),
    .err_uncorr   (err_uncorr),
    .scrub_uncorr (scrub_uncorr),
    .scr_re       (scr_re),
    .scr_we       (scr_we),
    .scr_adv      (scr_adv),
    .scr_addr     (scr_addr),
    .scr_state    (scr_state)
);

// File: tb/tb_ecc_scrub_mem.sv
module tb_ecc_scrub_mem;
    localparam int DW   = 16;
    localparam int AW   = 4;
    localparam int SW_A = 36;
    localparam int SW_B = 54;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] addr;
    logic          wr_en, rd_en;
    logic [DW-1:0] wr_data, rd_data;
    logic          rd_valid, err_corr, err_uncorr, scrub_uncorr;

    ecc_scrub_mem #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .err_corr(err_corr), .err_uncorr(err_uncorr), .scrub_uncorr(scrub_uncorr)
    );

    logic [1:0]  b_addr;
    logic        b_wr, b_rd;
    logic [39:0] b_wdata, b_rdata;
    logic        b_valid, b_corr, b_uncorr, b_sticky;

    ecc_scrub_mem #(.DATA_W(40), .ADDR_W(2)) dut2 (
        .clk(clk), .rst_n(rst_n), .addr(b_addr), .wr_en(b_wr), .rd_en(b_rd),
        .wr_data(b_wdata), .rd_data(b_rdata), .rd_valid(b_valid),
        .err_corr(b_corr), .err_uncorr(b_uncorr), .scrub_uncorr(b_sticky)
    );

    typedef struct {
        logic [DW-1:0] data;
        bit            chk_data;
        bit            corr;
        bit            uncorr;
        string         req;
    } exp_t;

    exp_t          sb[$];
    logic [DW-1:0] model [1 << AW];
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done  = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return 16'hA5C3 ^ (16'(a) * 16'h1111);
    endfunction

    // monitor: pops one expected item per rd_valid
    always @(negedge clk) begin
        exp_t e;
        if (rst_n && rd_valid) begin
            if (sb.size() == 0) begin
                check("R9 rd_valid without a read", 1, 0);
            end else begin
                e = sb.pop_front();
                check({e.req, " err_corr"}, err_corr, e.corr);
                check({e.req, " err_uncorr"}, err_uncorr, e.uncorr);
                if (e.chk_data) check({e.req, " rd_data"}, rd_data, e.data);
            end
        end
    end

    task automatic drive_idle(input int n);
        repeat (n) begin
            @(negedge clk);
            rd_en = 1'b0;
            wr_en = 1'b0;
        end
    endtask

    task automatic drive_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        addr    = AW'(a);
        wr_data = d;
        wr_en   = 1'b1;
        rd_en   = 1'b0;
        model[a] = d;
    endtask

    task automatic drive_read(input int a, input bit corr, input bit unc, input string req);
        @(negedge clk);
        addr  = AW'(a);
        rd_en = 1'b1;
        wr_en = 1'b0;
        sb.push_back('{model[a], !unc, corr, unc, req});
    endtask

    task automatic drive_read_inject(input int a, input logic [SW_A-1:0] mask,
                                     input bit corr, input bit unc, input string req);
        @(negedge clk);
        dut.u_array.mem[a] <= dut.u_array.mem[a] ^ mask;
        addr  = AW'(a);
        rd_en = 1'b1;
        wr_en = 1'b0;
        sb.push_back('{model[a], !unc, corr, unc, req});
    endtask

    initial begin
        int sa [5] = '{4, 6, 8, 11, 13};
        int sbit [5] = '{0, 1, 8, 15, 21};
        rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        b_addr = '0; b_wr = 1'b0; b_rd = 1'b0; b_wdata = '0;
        repeat (3) @(negedge clk);
        check("R10 rd_valid in reset", rd_valid, 0);
        check("R10 err_corr in reset", err_corr, 0);
        check("R10 err_uncorr in reset", err_uncorr, 0);
        check("R10 scrub_uncorr in reset", scrub_uncorr, 0);
        rst_n = 1'b1;

        check("R8 stored width at DATA_W=16", $bits(dut.u_array.mem[0]), SW_A);
        check("R8 stored width at DATA_W=40", $bits(dut2.u_array.mem[0]), SW_B);

        for (int a = 0; a < (1 << AW); a++) drive_write(a, pat(a));
        for (int a = 0; a < (1 << AW); a++) drive_read(a, 0, 0, "R1 readback");

        // R9: write and read together, write wins
        @(negedge clk);
        addr = 4'd3; wr_data = 16'h3C3C; wr_en = 1'b1; rd_en = 1'b1; model[3] = 16'h3C3C;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check("R9 no read when both enables high", rd_valid, 0);
        drive_read(3, 0, 0, "R9 written data");

        // R2: single flips, data, check and overall parity bits
        for (int k = 0; k < 5; k++)
            drive_read_inject(sa[k], SW_A'(1) << sbit[k], 1, 0, "R2 single flip");
        // R3: double flip
        drive_read_inject(10, (SW_A'(1) << 3) | (SW_A'(1) << 9), 0, 1, "R3 double flip");
        // R8: padding bit flip is ignored
        drive_read_inject(5, SW_A'(1) << 30, 0, 0, "R8 padding flip ignored");
        @(negedge clk);
        rd_en = 1'b0;
        check("R6 scrub_uncorr not set by user read", scrub_uncorr, 0);

        drive_idle(150);
        check("R6 scrub_uncorr after pass", scrub_uncorr, 1);
        for (int k = 0; k < 5; k++) drive_read(sa[k], 0, 0, "R5 scrubbed clean");
        drive_read(10, 0, 1, "R6 uncorrectable word left unchanged");

        // R7: traffic with at most two idle cycles keeps write-back cancelled
        drive_read_inject(2, SW_A'(1) << 5, 1, 0, "R7 inject");
        for (int k = 0; k < 60; k++) begin
            drive_idle(2);
            drive_read(0, 0, 0, "R7 user read under scrub");
        end
        drive_read(2, 1, 0, "R7 write-back cancelled by traffic");
        drive_idle(150);
        drive_read(2, 0, 0, "R7 retried at same address");

        // R6: overwrite the bad word, sticky stays
        drive_write(10, 16'h0F0F);
        drive_read(10, 0, 0, "R6 rewritten word clean");
        drive_idle(3);
        check("R6 scrub_uncorr sticky", scrub_uncorr, 1);

        // R5: ends of the address range across the wrap
        drive_read_inject(15, SW_A'(1) << 17, 1, 0, "R5 inject last");
        drive_read_inject(0, SW_A'(1) << 4, 1, 0, "R5 inject first");
        drive_idle(150);
        drive_read(15, 0, 0, "R5 last address scrubbed");
        drive_read(0, 0, 0, "R5 first address scrubbed after wrap");
        drive_idle(3);

        // R8/R2: wide instance, top code bit
        @(negedge clk);
        b_addr = 2'd1; b_wdata = 40'hC3_1234_5678; b_wr = 1'b1;
        @(negedge clk);
        b_wr = 1'b0;
        dut2.u_array.mem[1] <= dut2.u_array.mem[1] ^ (SW_B'(1) << 46);
        b_rd = 1'b1;
        @(negedge clk);
        b_rd = 1'b0;
        check("R2 wide rd_valid", b_valid, 1);
        check("R2 wide corrected data", b_rdata, 40'hC3_1234_5678);
        check("R2 wide err_corr", b_corr, 1);
        check("R2 wide err_uncorr", b_uncorr, 0);

        drive_idle(4);
        check("R1 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule